// File: doc/BRIEF.md
# LCD Sync and Active-Window Timing Generator

This block produces the raster timing for a 320 by 240 colour panel that is fed over a byte-wide data path. Each pixel takes either two byte-clock ticks (16-bit colour) or three ticks (24-bit colour), so every horizontal quantity is counted in ticks and scales with that factor. The generator drives active-low horizontal and vertical sync, a window flag that marks the ticks in which pixel bytes must be presented, and the column and row of the pixel being sent.

The start of the window is pushed back by the fixed latency of the downstream byte-to-pixel unpacker (3 ticks in the two-tick format, 5 ticks in the three-tick format), so the first byte reaches the panel in step with its pixel slot. The frame has four blank lines, split evenly: two ahead of the visible rows and two after them. Both syncs start from the same enable edge; dropping the enable stops all timing and a later enable starts a fresh frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `en` is low (and during reset), `hs_n` and `vs_n` are 1, `line_active` is 0 and `x_pos`, `y_pos` are 0, whatever `fmt_sel` does.
- R2: `fmt_sel` = 0 selects 2 ticks per pixel with a 3-tick unpacker delay; `fmt_sel` = 1 selects 3 ticks per pixel with a 5-tick delay. The value is taken at the clock edge that starts a run; changes during a run have no effect until the next start.
- R3: A line lasts 336 pixel times (336 x ticks-per-pixel ticks). `hs_n` is 0 for the first 2 pixel times of every line; tick 0 of the first line is the cycle after the edge that samples `en` high.
- R4: A frame lasts 244 lines. `vs_n` is 0 only during the first 2 pixel times of frame line 0, coinciding with that line's `hs_n` pulse.
- R5: On a visible line, `line_active` rises at tick 7 x ticks-per-pixel + delay of the line and stays high for 320 x ticks-per-pixel ticks.
- R6: `line_active` is high only on frame lines 2 to 241; lines 0, 1, 242 and 243 are blank.
- R7: While `line_active` is high, `x_pos` is the pixel column: 0 in the first window tick, advancing by one every ticks-per-pixel ticks. It is 0 outside the window.
- R8: While `line_active` is high, `y_pos` equals the frame line minus 2; it is 0 outside the window.
- R9: Lowering `en` returns all outputs to the idle state of R1 in the next cycle; raising it again restarts at tick 0 of frame line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; high runs the timing |
| fmt_sel | input | 1 | 0: two ticks per pixel, 1: three ticks per pixel |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| line_active | output | 1 | High in ticks that carry visible pixel bytes |
| x_pos | output | XW (9) | Pixel column inside the window |
| y_pos | output | YW (8) | Visible row inside the window |

## Verification
The bench builds the generator with an 8-pixel visible width inside a 14-pixel line, a 2-pixel lead, 4 visible rows and the 4 blank lines, keeping the unpacker delays at 3 and 5 ticks. With these values a whole frame is a few hundred ticks, so two complete frames in each format are compared tick by tick against an arithmetic model, covering line and frame wrap, the window edges with their odd delay offsets and the blank rows on both sides. Format changes in mid-run, an enable drop in mid-frame and the restart after it are within reach at the same size.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic {
    FMT_TWO_TICK   = 1'b0,
    FMT_THREE_TICK = 1'b1
  } pix_fmt_e;

  // ticks spent on one pixel in the byte-wide path
  function automatic int unsigned ticks_per_pix(pix_fmt_e f);
    return (f == FMT_THREE_TICK) ? 3 : 2;
  endfunction

  // a span given in pixel times, expressed in ticks
  function automatic int unsigned pix_to_ticks(pix_fmt_e f, int unsigned pix);
    return pix * ticks_per_pix(f);
  endfunction

  // first tick of the pixel window, unpacker latency included
  function automatic int unsigned window_open(pix_fmt_e f, int unsigned lead_pix,
                                              int unsigned dly_two, int unsigned dly_three);
    return pix_to_ticks(f, lead_pix) + ((f == FMT_THREE_TICK) ? dly_three : dly_two);
  endfunction

endpackage

// File: rtl/lcd_htick.sv
module lcd_htick #(
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] last_tick,
  output logic [HW-1:0] h_cnt,
  output logic          line_end
);

  assign line_end = run && (h_cnt == last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
    end else if (!run || line_end) begin
      h_cnt <= '0;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_vline.sv
module lcd_vline #(
  parameter int V_TOTAL = 244,
  parameter int VW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line_end,
  output logic [VW-1:0] v_cnt
);

  logic last_line;
  assign last_line = (v_cnt == VW'(V_TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_cnt <= '0;
    end else if (!run) begin
      v_cnt <= '0;
    end else if (line_end) begin
      v_cnt <= last_line ? '0 : v_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_window.sv
module lcd_window #(
  parameter int HW = 10,
  parameter int XW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] h_cnt,
  input  logic [HW-1:0] open_tick,
  input  logic [HW-1:0] close_tick,
  input  logic [1:0]    tpp,
  output logic          h_win,
  output logic [XW-1:0] col
);

  logic [1:0] phase;
  logic       phase_last;

  assign h_win      = (h_cnt >= open_tick) && (h_cnt < close_tick);
  assign phase_last = (phase == tpp - 2'd1);

  // column and phase sit at zero outside the window, so the first
  // window tick always presents column 0, phase 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      col   <= '0;
    end else if (!run || !h_win) begin
      phase <= '0;
      col   <= '0;
    end else if (phase_last) begin
      phase <= '0;
      col   <= col + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int H_VIS_PIX   = 320,
  parameter int H_TOTAL_PIX = 336,
  parameter int HS_PIX      = 2,
  parameter int VS_PIX      = 2,
  parameter int LEAD_PIX    = 7,
  parameter int V_VIS       = 240,
  parameter int V_BLANK     = 4,
  parameter int DLY_TWO     = 3,
  parameter int DLY_THREE   = 5,
  localparam int XW         = $clog2(H_VIS_PIX + 1),
  localparam int YW         = $clog2(V_VIS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fmt_sel,
  output logic          hs_n,
  output logic          vs_n,
  output logic          line_active,
  output logic [XW-1:0] x_pos,
  output logic [YW-1:0] y_pos
);

  localparam int HW      = $clog2(H_TOTAL_PIX * 3);
  localparam int V_TOTAL = V_VIS + V_BLANK;
  localparam int VW      = $clog2(V_TOTAL);
  localparam int V_PRE   = V_BLANK / 2;

  logic          run;
  pix_fmt_e      fmt_q;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          line_end;
  logic          h_win;
  logic          v_vis;
  logic [XW-1:0] col;

  // derived tick limits for the held format
  logic [1:0]    tpp;
  logic [HW-1:0] last_tick;
  logic [HW-1:0] hs_ticks;
  logic [HW-1:0] vs_ticks;
  logic [HW-1:0] open_tick;
  logic [HW-1:0] close_tick;

  assign tpp        = 2'(ticks_per_pix(fmt_q));
  assign last_tick  = HW'(pix_to_ticks(fmt_q, H_TOTAL_PIX) - 1);
  assign hs_ticks   = HW'(pix_to_ticks(fmt_q, HS_PIX));
  assign vs_ticks   = HW'(pix_to_ticks(fmt_q, VS_PIX));
  assign open_tick  = HW'(window_open(fmt_q, LEAD_PIX, DLY_TWO, DLY_THREE));
  assign close_tick = HW'(window_open(fmt_q, LEAD_PIX, DLY_TWO, DLY_THREE)
                          + pix_to_ticks(fmt_q, H_VIS_PIX));

  // run flag; the format is captured on every idle edge, so the value
  // present at the starting edge is the one held for the whole run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      fmt_q <= FMT_TWO_TICK;
    end else begin
      run <= en;
      if (!run) begin
        fmt_q <= pix_fmt_e'(fmt_sel);
      end
    end
  end

  lcd_htick #(
    .HW(HW)
  ) u_htick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .last_tick(last_tick),
    .h_cnt    (h_cnt),
    .line_end (line_end)
  );

  lcd_vline #(
    .V_TOTAL(V_TOTAL),
    .VW     (VW)
  ) u_vline (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .line_end(line_end),
    .v_cnt   (v_cnt)
  );

  lcd_window #(
    .HW(HW),
    .XW(XW)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .h_cnt     (h_cnt),
    .open_tick (open_tick),
    .close_tick(close_tick),
    .tpp       (tpp),
    .h_win     (h_win),
    .col       (col)
  );

  assign v_vis = (v_cnt >= VW'(V_PRE)) && (v_cnt < VW'(V_PRE + V_VIS));

  assign hs_n        = !(run && (h_cnt < hs_ticks));
  assign vs_n        = !(run && (v_cnt == '0) && (h_cnt < vs_ticks));
  assign line_active = run && h_win && v_vis;
  assign x_pos       = line_active ? col : '0;
  assign y_pos       = line_active ? YW'(v_cnt - VW'(V_PRE)) : '0;

endmodule

// File: rtl/lcd_sync_chk.sv
module lcd_sync_chk
  import lcd_sync_pkg::*;
#(
  parameter int HW      = 10,
  parameter int VW      = 8,
  parameter int XW      = 9,
  parameter int V_TOTAL = 244,
  parameter int V_PRE   = 2,
  parameter int V_VIS   = 240
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input pix_fmt_e      fmt_q,
  input logic          hs_n,
  input logic          vs_n,
  input logic          line_active,
  input logic [XW-1:0] x_pos,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          line_end,
  input logic [HW-1:0] hs_ticks
);

  // length of the current low stretch of hs_n
  logic [HW-1:0] lo_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_len <= '0;
    else if (hs_n)  lo_len <= '0;
    else            lo_len <= lo_len + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hs_n && vs_n && !line_active));

  p_fmt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(fmt_q));

  p_hs_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(hs_n)) |-> (lo_len == hs_ticks));

  p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_end) |=> (!run || (!hs_n && h_cnt == '0)));

  p_vs_line0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_n |-> (v_cnt == '0 && !hs_n));

  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_end && v_cnt == VW'(V_TOTAL - 1)) |=> (!run || v_cnt == '0));

  p_active_rows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |-> (v_cnt >= VW'(V_PRE) && v_cnt < VW'(V_PRE + V_VIS)));

  p_x_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_active && $past(line_active)) |->
      (x_pos == $past(x_pos) || x_pos == $past(x_pos) + 1'b1));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (h_cnt == '0 && v_cnt == '0 && !hs_n && !vs_n));

endmodule

bind lcd_sync_gen lcd_sync_chk #(
  .HW     (HW),
  .VW     (VW),
  .XW     (XW),
  .V_TOTAL(V_TOTAL),
  .V_PRE  (V_PRE),
  .V_VIS  (V_VIS)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .fmt_q      (fmt_q),
  .hs_n       (hs_n),
  .vs_n       (vs_n),
  .line_active(line_active),
  .x_pos      (x_pos),
  .h_cnt      (h_cnt),
  .v_cnt      (v_cnt),
  .line_end   (line_end),
  .hs_ticks   (hs_ticks)
);

// File: tb/test_lcd_sync_gen.sv
`timescale 1ns/1ps
module test_lcd_sync_gen;

  localparam int CLK_PERIOD = 10;

  localparam int T_HVIS  = 8;
  localparam int T_HTOT  = 14;
  localparam int T_HS    = 2;
  localparam int T_VS    = 2;
  localparam int T_LEAD  = 2;
  localparam int T_VVIS  = 4;
  localparam int T_VBL   = 4;
  localparam int T_DLY2  = 3;
  localparam int T_DLY3  = 5;
  localparam int T_XW    = $clog2(T_HVIS + 1);
  localparam int T_YW    = $clog2(T_VVIS);
  localparam int T_VTOT  = T_VVIS + T_VBL;
  localparam int T_PRE   = T_VBL / 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            en;
  logic            fmt_sel;
  logic            hs_n, vs_n, line_active;
  logic [T_XW-1:0] x_pos;
  logic [T_YW-1:0] y_pos;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_sync_gen #(
    .H_VIS_PIX  (T_HVIS),
    .H_TOTAL_PIX(T_HTOT),
    .HS_PIX     (T_HS),
    .VS_PIX     (T_VS),
    .LEAD_PIX   (T_LEAD),
    .V_VIS      (T_VVIS),
    .V_BLANK    (T_VBL),
    .DLY_TWO    (T_DLY2),
    .DLY_THREE  (T_DLY3)
  ) i_lcd_sync_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .fmt_sel    (fmt_sel),
    .hs_n       (hs_n),
    .vs_n       (vs_n),
    .line_active(line_active),
    .x_pos      (x_pos),
    .y_pos      (y_pos)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(hs_n == 1'b1, {tag, " hs_n idle"}, int'(hs_n), 1);
    chk(vs_n == 1'b1, {tag, " vs_n idle"}, int'(vs_n), 1);
    chk(line_active == 1'b0, {tag, " line_active idle"}, int'(line_active), 0);
    chk(x_pos == '0, {tag, " x_pos idle"}, int'(x_pos), 0);
    chk(y_pos == '0, {tag, " y_pos idle"}, int'(y_pos), 0);
  endtask

  // compare every output against the arithmetic model at tick t of a run
  task automatic chk_tick(input int fmt, input int t);
    int cpp, lt, h, v, s, e;
    bit act;
    int ex, ey;
    cpp = fmt ? 3 : 2;
    lt  = T_HTOT * cpp;
    h   = t % lt;
    v   = (t / lt) % T_VTOT;
    s   = T_LEAD * cpp + (fmt ? T_DLY3 : T_DLY2);
    e   = s + T_HVIS * cpp;
    act = (v >= T_PRE) && (v < T_PRE + T_VVIS) && (h >= s) && (h < e);
    ex  = act ? (h - s) / cpp : 0;
    ey  = act ? v - T_PRE : 0;
    chk(hs_n == !(h < T_HS * cpp), "R3 hs_n", int'(hs_n), int'(!(h < T_HS * cpp)));
    chk(vs_n == !(v == 0 && h < T_VS * cpp), "R4 vs_n", int'(vs_n),
        int'(!(v == 0 && h < T_VS * cpp)));
    chk(line_active == act, "R5 R6 line_active", int'(line_active), int'(act));
    chk(int'(x_pos) == ex, "R7 x_pos", int'(x_pos), ex);
    chk(int'(y_pos) == ey, "R8 y_pos", int'(y_pos), ey);
  endtask

  // start a run with format fmt, check n ticks, then drop the enable
  // r2_: when flip_at >= 0 the select is inverted at that tick; the
  // expected timing keeps the starting format
  task automatic run_fmt(input int fmt, input int n, input int flip_at);
    fmt_sel = fmt[0];
    en      = 1'b1;
    for (int t = 0; t < n; t++) begin
      @(posedge clk); #1;
      chk_tick(fmt, t);
      if (t == flip_at) fmt_sel = ~fmt_sel;
    end
    en = 1'b0;
    @(posedge clk); #1;
    chk_idle("R9 stop");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    en      = 1'b0;
    fmt_sel = 1'b0;
    #1;
    chk_idle("R1 reset");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: enable low, format toggling has no effect on the outputs
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk_idle("R1 enable low");
      fmt_sel = ~fmt_sel;
    end

    // two full frames in each format, with a mid-run select flip (R2)
    run_fmt(0, 2 * T_VTOT * T_HTOT * 2 + 20, 50);
    run_fmt(1, 2 * T_VTOT * T_HTOT * 3 + 20, 77);

    // R9: stop inside a visible line, stay idle, restart from tick 0
    run_fmt(1, 150, -1);
    @(posedge clk); #1;
    chk_idle("R9 held low");
    run_fmt(0, 130, -1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule